// File: doc/BRIEF.md
# Stream Width Packer

This block joins a narrow valid/ready stream to a stream that is a fixed factor wider. It collects `N` consecutive accepted elements of `W` bits and hands them on as one word of `N*W` bits. The first element of a group lands in the most significant slice, so the wide word has the same byte image as the narrow stream laid out in memory.

The first `N-1` elements of a group are held in registers. The last element is not registered. It is placed straight into the low slice of the outgoing word, beside the held elements. The wide word therefore becomes valid in the same cycle that the last element is offered, and the delay through the block is 0 cycles for the last element of a group and `N-1` cycles for the first. While the last element waits, the input is stalled for exactly as long as the output is stalled.

Top module: `stream_width_packer`

## Requirements
- R1: `out_data` is `N*W` bits wide, and `out_valid` rises once for every `N` input elements accepted. It stays low while a group is incomplete.
- R2: Within `out_data`, the element accepted first sits in bits `[N*W-1 -: W]`. Each later element sits `W` bits lower, and the last element occupies bits `[W-1:0]`.
- R3: For the first `N-1` elements of a group, `in_ready` is high whatever `out_ready` is, and each element offered is captured.
- R4: When the last element of a group is offered, `out_valid` is high in that same cycle and `in_ready` equals `out_ready`.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values and no input element is consumed.
- R6: Once a wide word is accepted, the group count returns to zero, so the next element starts a new group in the top slice.
- R7: A synchronous reset clears the group count and holds `out_valid` low. Any partly filled group is dropped.
- R8: Cycles in which `in_valid` is low advance nothing: they do not count toward the group and they do not change the word that is later produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Narrow element offered |
| in_ready | output | 1 | Narrow element can be taken |
| in_data | input | W | Narrow element |
| out_valid | output | 1 | Wide word offered |
| out_ready | input | 1 | Wide word can be taken |
| out_data | output | N*W | Wide word, earliest element in the top slice |

## Verification
The bench stalls the wide side on the last element of a group. A design that let the input run ahead would lose or double-count that element, and a design that dropped `out_valid` early would break the handshake. Idle cycles are placed inside groups; a counter that advanced on them would misplace every later slice. The bench also withholds `out_ready` during the first elements of a group to show the input still flows, and resets in the middle of a group to show that stale slices never reach the output. Back-to-back groups check the wrap of the count, because an off-by-one there shifts the whole next word.

// File: rtl/packer_pkg.sv
package packer_pkg;

  // Bit offset of slot idx inside a word of n slices, earliest slot on top.
  function automatic int slice_lsb(int idx, int n, int w);
    return (n - 1 - idx) * w;
  endfunction

  // Group position after one accepted element.
  function automatic int step_slot(int cur, int n);
    return (cur == n - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/pk_slot_counter.sv
module pk_slot_counter #(
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] slot_q,
  output logic          at_last
);
  import packer_pkg::*;

  logic [CW-1:0] slot_d;

  assign at_last = (slot_q == CW'(N - 1));
  assign slot_d  = CW'(step_slot(int'(slot_q), N));

  always_ff @(posedge clk) begin
    if (rst)      slot_q <= '0;
    else if (adv) slot_q <= slot_d;
  end
endmodule

// File: rtl/pk_slice_store.sv
module pk_slice_store #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1,
  localparam int HW = (N - 1) * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_slot,
  input  logic [W-1:0]  wr_data,
  output logic [HW-1:0] held_word
);
  import packer_pkg::*;

  for (genvar k = 0; k < N - 1; k++) begin : g_slice
    logic [W-1:0] slice_q;
    always_ff @(posedge clk) begin
      if (rst)                                  slice_q <= '0;
      else if (wr_en && wr_slot == CW'(k))      slice_q <= wr_data;
    end
    assign held_word[slice_lsb(k, N - 1, W) +: W] = slice_q;
  end
endmodule

// File: rtl/stream_width_packer.sv
module stream_width_packer #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1,
  localparam int OW = N * W,
  localparam int HW = (N - 1) * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_data
);
  // Named internal events, used by the checker.
  logic [CW-1:0] slot_q;
  logic          grp_last;
  logic          take_in;
  logic          emit_out;
  logic [HW-1:0] held_word;

  pk_slot_counter #(.N(N)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .adv     (take_in),
    .slot_q  (slot_q),
    .at_last (grp_last)
  );

  pk_slice_store #(.W(W), .N(N)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (take_in && !grp_last),
    .wr_slot   (slot_q),
    .wr_data   (in_data),
    .held_word (held_word)
  );

  assign out_valid = in_valid && grp_last && !rst;
  assign in_ready  = !rst && (grp_last ? out_ready : 1'b1);
  assign take_in   = in_valid && in_ready;
  assign emit_out  = out_valid && out_ready;
  assign out_data  = {held_word, in_data};
endmodule

// File: rtl/stream_width_packer_chk.sv
module stream_width_packer_chk #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1,
  localparam int OW = N * W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_data,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic [CW-1:0] slot_q,
  input logic          take_in,
  input logic          emit_out
);
  assert_fire_on_full_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (slot_q == CW'(N - 1)));

  assert_last_low_slice_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[W-1:0] == in_data));

  assert_early_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (slot_q != CW'(N - 1)) |-> in_ready);

  assert_last_ready_tie_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && slot_q == CW'(N - 1)) |-> (out_valid && in_ready == out_ready));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    emit_out |=> (slot_q == '0));

  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (take_in && !emit_out) |=> (slot_q == $past(slot_q) + 1'b1));

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (slot_q == '0 && !out_valid));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(slot_q));
endmodule

bind stream_width_packer stream_width_packer_chk #(.W(W), .N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .slot_q    (slot_q),
  .take_in   (take_in),
  .emit_out  (emit_out)
);

// File: tb/stream_width_packer_bench.sv
module stream_width_packer_bench;
  localparam int W  = 8;
  localparam int N  = 4;
  localparam int OW = N * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_data = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  stream_width_packer #(.W(W), .N(N)) u_stream_width_packer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Expected word: earliest element shifted up as later ones arrive.
  function automatic logic [OW-1:0] pack(input logic [W-1:0] e [N]);
    logic [OW-1:0] acc = '0;
    for (int i = 0; i < N; i++) acc = (acc << W) | OW'(e[i]);
    return acc;
  endfunction

  // Offer one group; stall the wide side `stall` cycles on the last element,
  // optionally hold out_ready low during the early elements, and insert
  // `gaps` idle cycles before each element.
  task automatic run_group(input logic [W-1:0] base, input int stall,
                           input bit early_block, input int gaps);
    logic [W-1:0] e [N];
    logic [OW-1:0] exp;
    for (int i = 0; i < N; i++) e[i] = base + W'(i * 17);
    exp = pack(e);
    for (int i = 0; i < N; i++) begin
      for (int g = 0; g < gaps; g++) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = 8'hEE; out_ready = 1'b1;
        #2 check(!out_valid, "R8 idle cycle raises no output", 64'(out_valid), 0);
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = e[i];
      out_ready = (i < N - 1) ? !early_block : 1'b1;
      if (i < N - 1) begin
        #2;
        check(in_ready, "R3 early element ready", 64'(in_ready), 1);
        check(!out_valid, "R1 no output before group full", 64'(out_valid), 0);
      end else begin
        for (int s = 0; s < stall; s++) begin
          out_ready = 1'b0;
          #2;
          check(out_valid, "R4 output valid with last element", 64'(out_valid), 1);
          check(!in_ready, "R5 input stalled with output", 64'(in_ready), 0);
          check(out_data == exp, "R5 data held under stall", 64'(out_data), 64'(exp));
          @(negedge clk);
        end
        out_ready = 1'b1;
        #2;
        check(out_valid && in_ready, "R4 last element passes with output",
              64'({out_valid, in_ready}), 64'h3);
        check(out_data == exp, "R2 slice order", 64'(out_data), 64'(exp));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #2 check(!out_valid, "R6 output drops after group", 64'(out_valid), 0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(!out_valid, "R7 out_valid low in reset", 64'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R7 out_valid low after reset", 64'(out_valid), 0);
    check(in_ready, "R7 ready at group start", 64'(in_ready), 1);
  endtask

  task automatic t_midgroup_reset();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hA0 + W'(i);
    end
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2 check(!out_valid, "R7 reset drops partial group", 64'(out_valid), 0);
    run_group(8'h30, 0, 1'b0, 0);
  endtask

  initial begin
    #(20 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    t_reset_state();
    run_group(8'h10, 0, 1'b0, 0);
    run_group(8'h51, 0, 1'b0, 0);
    run_group(8'hC3, 3, 1'b0, 0);
    run_group(8'h07, 1, 1'b1, 0);
    run_group(8'h9A, 0, 1'b0, 2);
    t_midgroup_reset();
    run_group(8'hF0, 2, 1'b1, 1);
    finish_run();
  end
endmodule